// File: doc/BRIEF.md
# ADC Channel Sequence Controller

This block runs a series of conversions on a multi-input ADC. Software writes one 32-bit control word that names the last channel of the series, the decimation rate and the reference source. A start pulse then makes the block walk through the channel range that the last-channel code implies. For each channel it marks the first cycle of the conversion to the modulator and counts one decimation period. In the final cycle of that period it presents the modulator's sample with the channel code and a one-cycle valid strobe.

The channel range depends on the last-channel code. Codes 0 to 7 sweep the single-ended inputs upward from 0. Codes 8 to 11 sweep the differential pairs upward from code 8. Codes 12 and above (ground, reserved, temperature sensor, a third of the supply) convert once on that code only. While a series runs, the channel field of the control word reads back the channel being converted. Reference, rate and range are copied when a series starts, so later writes wait for the next start.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0, and busy, done and the result strobe are all low.
- R2: Write data bits 7:6 set the reference code, bits 5:4 the rate code and bits 3:0 the last-channel code. Bits 31:8 are not stored and always read as 0.
- R3: A last-channel code N of 7 or less converts channels 0, 1, …, N in ascending order.
- R4: A last-channel code N from 8 to 11 converts codes 8, 9, …, N in ascending order.
- R5: A last-channel code of 12 to 15 makes exactly one conversion, on that code.
- R6: Every conversion lasts BASE_DEC shifted left by the rate code cycles (64, 128, 256 or 512 by default). conv_go is high in its first cycle and result_valid in its last cycle, and the next conversion begins in the following cycle.
- R7: When result_valid is high, result_ch carries the code being converted and result_data equals mod_data in that cycle.
- R8: Read bits 3:0 return the current channel while busy and the stored last-channel code when idle. Bits 7:4 always return the stored reference and rate codes.
- R9: A start while busy is ignored. Writes during a series update the stored word but leave mod_ref, mod_rate and the channel range of the running series unchanged.
- R10: busy falls and done rises in the cycle after the last result_valid. done stays high until the next accepted start clears it.
- R11: A write and a start in the same cycle start the series with the word stored before that write. The written word is kept for later starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control word write enable |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data (live channel while busy) |
| start | input | 1 | Start pulse for a series |
| mod_data | input | DW | Sample from the modulator/filter |
| conv_go | output | 1 | First cycle of each conversion |
| mod_ch | output | 4 | Channel code being converted |
| mod_ref | output | 2 | Reference code for the running series |
| mod_rate | output | 2 | Rate code for the running series |
| result_valid | output | 1 | Last cycle of a conversion; result is valid |
| result_ch | output | 4 | Channel code of the result |
| result_data | output | DW | Result sample |
| busy | output | 1 | Series in progress |
| done | output | 1 | Last series completed |

## Verification
Two functions can fall in the same cycle. A start can coincide with a control-word write, and a start can arrive in the cycle of a series' final result strobe. The bench drives both: write and start on the same edge, and start during the last result_valid. It judges them against its cycle-by-cycle model. The first must run the old range and rate and keep the new word stored. The second must be dropped, so busy falls and done rises with no new series.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int BASE_DEC = 64,
  parameter int DW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          start,
  input  logic [DW-1:0] mod_data,
  output logic          conv_go,
  output logic [3:0]    mod_ch,
  output logic [1:0]    mod_ref,
  output logic [1:0]    mod_rate,
  output logic          result_valid,
  output logic [3:0]    result_ch,
  output logic [DW-1:0] result_data,
  output logic          busy,
  output logic          done
);

  localparam int CW = $clog2(BASE_DEC * 8) + 1;
  localparam logic [CW-1:0] BASE = CW'(BASE_DEC);

  logic [7:0]    cfg_q;
  logic          busy_q, done_q;
  logic [3:0]    cur_q, last_q;
  logic [1:0]    ref_q, rate_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;
  logic [3:0]    first_ch;
  logic          conv_end, accept;

  assign len      = BASE << rate_q;
  assign conv_end = (cnt_q == len - 1'b1);
  assign accept   = start && !busy_q;

  always_comb begin
    if (cfg_q[3:0] <= 4'd7)       first_ch = 4'd0;
    else if (cfg_q[3:0] <= 4'd11) first_ch = 4'd8;
    else                          first_ch = cfg_q[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      ref_q  <= '0;
      rate_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (reg_we) cfg_q <= reg_wdata[7:0];
      if (accept) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cur_q  <= first_ch;
        last_q <= cfg_q[3:0];
        ref_q  <= cfg_q[7:6];
        rate_q <= cfg_q[5:4];
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (conv_end) begin
          cnt_q <= '0;
          if (cur_q == last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cur_q <= cur_q + 4'd1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign reg_rdata    = {24'd0, cfg_q[7:4], busy_q ? cur_q : cfg_q[3:0]};
  assign conv_go      = busy_q && (cnt_q == '0);
  assign result_valid = busy_q && conv_end;
  assign result_ch    = cur_q;
  assign result_data  = result_valid ? mod_data : '0;
  assign mod_ch       = cur_q;
  assign mod_ref      = ref_q;
  assign mod_rate     = rate_q;
  assign busy         = busy_q;
  assign done         = done_q;

  AST_CH_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mod_ch != $past(mod_ch)) |-> mod_ch == $past(mod_ch) + 4'd1); // R3
  AST_SPECIAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_q >= 4'd12) |-> mod_ch == last_q); // R5
  AST_GO_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && mod_ch != last_q) |=> conv_go); // R6
  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mod_ref) && $stable(mod_rate))); // R9
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_VALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> busy); // R7

endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  localparam int BASE = 64;
  localparam int DW   = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic          start = 1'b0;
  logic [DW-1:0] mod_data = '0;
  logic [31:0]   reg_rdata;
  logic          conv_go, result_valid, busy, done;
  logic [3:0]    mod_ch, result_ch;
  logic [1:0]    mod_ref, mod_rate;
  logic [DW-1:0] result_data;

  adc_seq_ctrl #(.BASE_DEC(BASE), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .start(start), .mod_data(mod_data),
    .conv_go(conv_go), .mod_ch(mod_ch), .mod_ref(mod_ref), .mod_rate(mod_rate),
    .result_valid(result_valid), .result_ch(result_ch), .result_data(result_data),
    .busy(busy), .done(done));

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit armed = 0, finished = 0;

  int m_reg = 0, m_busy = 0, m_done = 0, m_ch = 0, m_end = 0;
  int m_ref = 0, m_rate = 0, m_cnt = 0;
  int exp_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string range_tag(int e);
    if (e <= 7) return "R3 channel order";
    if (e <= 11) return "R4 pair order";
    return "R5 single conversion";
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_busy = 0; m_done = 0; m_ch = 0; m_cnt = 0; m_ref = 0; m_rate = 0;
    end else begin
      if (start && m_busy == 0) begin
        int e;
        e = m_reg % 16;
        m_end = e; m_ref = m_reg / 64; m_rate = (m_reg / 16) % 4;
        m_ch = (e > 11) ? e : ((e > 7) ? 8 : 0);
        for (int c = m_ch; c <= e; c++) exp_q.push_back(c);
        m_busy = 1; m_done = 0; m_cnt = 0;
      end else if (m_busy == 1) begin
        if (m_cnt == BASE * (1 << m_rate) - 1) begin
          m_cnt = 0;
          if (m_ch == m_end) begin m_busy = 0; m_done = 1; end
          else m_ch++;
        end else m_cnt++;
      end
      if (reg_we) m_reg = reg_wdata % 256;
    end
    armed = rst_n;
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    if (armed && !finished) begin
      int ev;
      ev = (m_busy == 1 && m_cnt == BASE * (1 << m_rate) - 1) ? 1 : 0;
      chk("R10 busy", busy, m_busy);
      chk("R10 done", done, m_done);
      chk("R6 conv_go", conv_go, (m_busy == 1 && m_cnt == 0) ? 1 : 0);
      chk("R6 result_valid", result_valid, ev);
      chk("R2/R8 readback", reg_rdata,
          (m_reg / 16) * 16 + ((m_busy == 1) ? m_ch : m_reg % 16));
      if (m_busy == 1) begin
        chk("R9 mod_ref", mod_ref, m_ref);
        chk("R9 mod_rate", mod_rate, m_rate);
        chk("R8 mod_ch", mod_ch, m_ch);
      end
      if (ev == 1) begin
        chk("R7 result_data", result_data, mod_data);
        if (exp_q.size() == 0) chk("R3 unexpected result", 1, 0);
        else chk(range_tag(m_end), result_ch, exp_q.pop_front());
      end
      if (m_done == 1 && m_busy == 0) chk("R3 queue drained", exp_q.size(), 0);
      mod_data <= DW'((mod_data * 5 + 3));
    end
  end

  task automatic do_write(logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(logic [31:0] v);
    do_write(v); do_start(); wait_idle();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 valid", result_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reserved bits dropped
    do_write(32'hDEAD_BEA5);
    chk("R2 fields", reg_rdata, 32'h0000_00A5);
    do_start(); wait_idle();
    run(32'h0000_0007);                 // R3 full single-ended sweep
    run(32'h0000_0000);                 // R3 single channel 0
    run(32'h0000_0048);                 // R4 one pair
    run(32'h0000_00FB);                 // R4 all pairs, rate 512
    run(32'h0000_001C);                 // R5 ground
    run(32'h0000_002D);                 // R5 reserved
    run(32'h0000_000E);                 // R5 temperature
    run(32'h0000_009F);                 // R5 supply/3
    // R9: start and write while busy
    do_write(32'h0000_0013);
    do_start();
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    do_write(32'h0000_00E6);
    chk("R9 rate held", mod_rate, 1);
    chk("R9 ref held", mod_ref, 0);
    wait_idle();
    chk("R9 stored for next", reg_rdata, 32'h0000_00E6);
    // R11: write and start on the same edge
    do_write(32'h0000_0003);
    @(negedge clk); reg_we = 1'b1; reg_wdata = 32'h0000_001E; start = 1'b1;
    @(negedge clk); reg_we = 1'b0; start = 1'b0;
    chk("R11 old rate used", mod_rate, 0);
    chk("R11 old range used", mod_ch, 0);
    chk("R11 new word stored", reg_rdata[7:4], 4'h1);
    wait_idle();
    // R10/R9: start during the final result strobe is dropped
    do_write(32'h0000_0001);
    do_start();
    @(negedge clk);
    while (!(result_valid && result_ch == 4'd1)) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R10 busy fell", busy, 0);
    chk("R10 done set", done, 1);
    repeat (4) @(negedge clk);
    chk("R9 late start ignored", busy, 0);
    finish_run();
  end
endmodule